// File: doc/BRIEF.md
# Instruction Decoder with Immediate and Constant Generation

This block turns one 32-bit instruction word of a small 64-bit load/store machine into the control and operand information that the rest of the pipeline consumes. The most significant byte selects the operation. The lower 24 bits are split into up to three 8-bit fields. Depending on the operation, those fields are read as register indices, as a sign- or zero-extended immediate, or as a signed jump offset. The decoder does not read the register file, access memory or perform arithmetic. Its outputs tell those units which register fields to use, which ALU function to apply and whether a memory access is a single byte or a full 64-bit word.

Three constant-building operations are finished inside the decoder. Each needs at most one adder or one shift, so no ALU pass is spent on them. The caller supplies the current instruction pointer and the present value of the destination register. The decoder then returns the finished write-back value for three cases: a zero-extended 16-bit load, a 16-bit shift-and-insert, and a pool address formed relative to the instruction pointer. Opcodes 0x01 through 0x1A are defined. Any other opcode is flagged as illegal, and every write enable is held low for it. All outputs are registered, so each decode result appears one clock after its instruction word.

Top module: `insn_decoder`

## Requirements
- R1: All outputs come from registers. The result for the instruction, IP and register value present at one rising edge appears after that edge. While the active-low reset is asserted, every output is zero.
- R2: For every opcode, rx is insn[23:16], ry is insn[15:8] and rz is insn[7:0].
- R3: imm is the value carried by the instruction:
  - For jumps 0x04, 0x06, 0x07, 0x0C and 0x0D, imm is insn[23:0] sign-extended.
  - For 0x08 and 0x15, imm is insn[15:0] zero-extended.
  - For 0x16, imm is insn[15:0] sign-extended.
  - For memory forms 0x09, 0x11, 0x12 and 0x19, imm is insn[15:8] sign-extended.
  - For 0x17, imm is insn[15:8] zero-extended and multiplied by 8.
  - For every other legal opcode, imm is insn[23:16] zero-extended.
  - For an illegal opcode, imm is zero.
- R4: alu_op is 1 for add (0x0A, 0x0E), 2 for subtract (0x05, 0x18), 3 for multiply (0x0F, 0x0B) and 4 for divide (0x10, 0x1A). It is 0 for all other opcodes. x_is_imm is 1 exactly for 0x05, 0x0A, 0x0F, 0x10 and 0x13.
- R5: mem_rd is 1 for loads 0x09, 0x12 and 0x17. mem_wr is 1 for stores 0x11 and 0x19. mem_byte is 1 only for the byte forms 0x09 and 0x11; the byte load is zero-extended. mem_rd and mem_wr are never 1 together.
- R6: wb_const_valid is 1 exactly for 0x08, 0x15 and 0x16. For 0x08, wb_value is zero-extended insn[15:0]. For 0x15, it is (rz_val shifted left 16) OR zero-extended insn[15:0]. For 0x16, it is ip plus sign-extended insn[15:0], modulo 2^64. Otherwise wb_value is 0.
- R7: br_cond is 1 (always) for 0x04, 2 (zero flag clear) for 0x06, 3 (zero flag set) for 0x07, 4 (above) for 0x0C and 5 (below) for 0x0D. It is 0 for all other opcodes. link_we is 1 only for the register jump 0x14, which writes the return address to register ry.
- R8: reg_we (write to register rz) is 1 exactly for 0x02, 0x05, 0x08, 0x09, 0x0A, 0x0B, 0x0E, 0x0F, 0x10, 0x12, 0x15, 0x16, 0x17, 0x18 and 0x1A. pair_we (remainder written to rz+1) is 1 exactly for 0x10 and 0x1A.
- R9: op_class is one of the following:
  - 1 (ALU) for 0x05, 0x0A, 0x0B, 0x0E, 0x0F, 0x10, 0x18, 0x1A;
  - 2 (relative branch) for the jump opcodes of R7;
  - 3 (register jump) for 0x14;
  - 4 (load) for 0x09, 0x12, 0x17;
  - 5 (store) for 0x11, 0x19;
  - 6 (constant) for 0x08, 0x15, 0x16;
  - 7 (system) for 0x01, 0x02, 0x03, 0x13.

  sys_op is 1 for halt (0x01), 2 for character input (0x02) and 3 for character output (0x03, 0x13). It is 0 otherwise.
- R10: Opcode 0x00 and every opcode above 0x1A set illegal to 1 and op_class to 0. They also clear imm, alu_op, x_is_imm, br_cond, sys_op, every memory flag, every write enable and wb_value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 32 | Instruction word; the opcode is in bits 31:24 |
| ip | input | XLEN | Current instruction pointer |
| rz_val | input | XLEN | Present value of the register named by insn[7:0] |
| illegal | output | 1 | Unknown opcode |
| op_class | output | 3 | Operation class (R9) |
| rx | output | 8 | First field, insn[23:16] |
| ry | output | 8 | Second field, insn[15:8] |
| rz | output | 8 | Third field, insn[7:0] |
| imm | output | XLEN | Extended immediate (R3) |
| alu_op | output | 3 | ALU function (R4) |
| x_is_imm | output | 1 | First ALU operand is the immediate, not register rx |
| br_cond | output | 3 | Relative branch condition (R7) |
| mem_rd | output | 1 | Memory load |
| mem_wr | output | 1 | Memory store |
| mem_byte | output | 1 | Access is one byte rather than eight |
| reg_we | output | 1 | Write register rz |
| pair_we | output | 1 | Also write remainder to register rz+1 |
| link_we | output | 1 | Write the return address to register ry |
| sys_op | output | 2 | System operation (R9) |
| wb_const_valid | output | 1 | wb_value holds a finished constant result |
| wb_value | output | XLEN | Constant write-back value (R6) |

## Verification
Every result of this block is due on the first rising edge after its instruction word, IP and register value are presented, and not before. The bench therefore changes inputs on a falling edge and compares outputs on the next falling edge. At that point exactly one register stage lies between stimulus and sample. All 256 opcodes are swept, each with five field patterns. The patterns cover all-zero fields, all-one fields, sign-bit boundaries and an IP near zero, so that the relative pool address wraps. The expected value of each output is derived from the opcode lists and arithmetic in the requirements.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int INSN_W   = 32;
    localparam int FLD_W    = 8;
    localparam int OP_W     = INSN_W - 3 * FLD_W;
    localparam int FIELDS_W = 3 * FLD_W;
    localparam int HALF_W   = 2 * FLD_W;

    typedef enum logic [2:0] {
        CLS_ILLEGAL = 3'd0, CLS_ALU = 3'd1, CLS_BRANCH = 3'd2, CLS_JUMPREG = 3'd3,
        CLS_LOAD = 3'd4, CLS_STORE = 3'd5, CLS_CONST = 3'd6, CLS_SYS = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        ALU_NONE = 3'd0, ALU_ADD = 3'd1, ALU_SUB = 3'd2, ALU_MUL = 3'd3, ALU_DIV = 3'd4
    } alu_e;

    typedef enum logic [2:0] {
        BR_NONE = 3'd0, BR_ALWAYS = 3'd1, BR_NZ = 3'd2, BR_Z = 3'd3,
        BR_ABOVE = 3'd4, BR_BELOW = 3'd5
    } br_e;

    typedef enum logic [1:0] {
        SYS_NONE = 2'd0, SYS_HALT = 2'd1, SYS_GETC = 2'd2, SYS_PUTC = 2'd3
    } sys_e;

    typedef enum logic [2:0] {
        LAY_NONE = 3'd0, LAY_RRR = 3'd1, LAY_RRR_SC8 = 3'd2, LAY_RSR = 3'd3,
        LAY_J24 = 3'd4, LAY_U16 = 3'd5, LAY_S16 = 3'd6
    } layout_e;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0, CK_ZEXT16 = 2'd1, CK_SHIFT16 = 2'd2, CK_IPREL = 2'd3
    } const_e;

    typedef struct packed {
        logic      illegal;
        op_class_e cls;
        alu_e      alu;
        logic      x_imm;
        br_e       br;
        logic      mem_rd;
        logic      mem_wr;
        logic      mem_byte;
        logic      reg_we;
        logic      pair_we;
        logic      link_we;
        sys_e      sys;
        layout_e   layout;
        const_e    ckind;
    } ctrl_t;
endpackage

// File: rtl/insn_dec_ctrl.sv
module insn_dec_ctrl
    import dec_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.illegal  = 1'b0;
        ctrl.cls      = CLS_ILLEGAL;
        ctrl.alu      = ALU_NONE;
        ctrl.br       = BR_NONE;
        ctrl.sys      = SYS_NONE;
        ctrl.layout   = LAY_RRR;
        ctrl.ckind    = CK_NONE;
        case (opcode)
            8'h01: begin ctrl.cls = CLS_SYS; ctrl.sys = SYS_HALT; end
            8'h02: begin ctrl.cls = CLS_SYS; ctrl.sys = SYS_GETC; ctrl.reg_we = 1'b1; end
            8'h03: begin ctrl.cls = CLS_SYS; ctrl.sys = SYS_PUTC; end
            8'h13: begin ctrl.cls = CLS_SYS; ctrl.sys = SYS_PUTC; ctrl.x_imm = 1'b1; end
            8'h04: begin ctrl.cls = CLS_BRANCH; ctrl.br = BR_ALWAYS; ctrl.layout = LAY_J24; end
            8'h06: begin ctrl.cls = CLS_BRANCH; ctrl.br = BR_NZ;     ctrl.layout = LAY_J24; end
            8'h07: begin ctrl.cls = CLS_BRANCH; ctrl.br = BR_Z;      ctrl.layout = LAY_J24; end
            8'h0C: begin ctrl.cls = CLS_BRANCH; ctrl.br = BR_ABOVE;  ctrl.layout = LAY_J24; end
            8'h0D: begin ctrl.cls = CLS_BRANCH; ctrl.br = BR_BELOW;  ctrl.layout = LAY_J24; end
            8'h14: begin ctrl.cls = CLS_JUMPREG; ctrl.link_we = 1'b1; end
            8'h0A: begin ctrl.cls = CLS_ALU; ctrl.alu = ALU_ADD; ctrl.x_imm = 1'b1; ctrl.reg_we = 1'b1; end
            8'h0E: begin ctrl.cls = CLS_ALU; ctrl.alu = ALU_ADD; ctrl.reg_we = 1'b1; end
            8'h05: begin ctrl.cls = CLS_ALU; ctrl.alu = ALU_SUB; ctrl.x_imm = 1'b1; ctrl.reg_we = 1'b1; end
            8'h18: begin ctrl.cls = CLS_ALU; ctrl.alu = ALU_SUB; ctrl.reg_we = 1'b1; end
            8'h0F: begin ctrl.cls = CLS_ALU; ctrl.alu = ALU_MUL; ctrl.x_imm = 1'b1; ctrl.reg_we = 1'b1; end
            8'h0B: begin ctrl.cls = CLS_ALU; ctrl.alu = ALU_MUL; ctrl.reg_we = 1'b1; end
            8'h10: begin
                ctrl.cls = CLS_ALU; ctrl.alu = ALU_DIV; ctrl.x_imm = 1'b1;
                ctrl.reg_we = 1'b1; ctrl.pair_we = 1'b1;
            end
            8'h1A: begin
                ctrl.cls = CLS_ALU; ctrl.alu = ALU_DIV;
                ctrl.reg_we = 1'b1; ctrl.pair_we = 1'b1;
            end
            8'h09: begin
                ctrl.cls = CLS_LOAD; ctrl.mem_rd = 1'b1; ctrl.mem_byte = 1'b1;
                ctrl.reg_we = 1'b1; ctrl.layout = LAY_RSR;
            end
            8'h12: begin ctrl.cls = CLS_LOAD; ctrl.mem_rd = 1'b1; ctrl.reg_we = 1'b1; ctrl.layout = LAY_RSR; end
            8'h17: begin ctrl.cls = CLS_LOAD; ctrl.mem_rd = 1'b1; ctrl.reg_we = 1'b1; ctrl.layout = LAY_RRR_SC8; end
            8'h11: begin ctrl.cls = CLS_STORE; ctrl.mem_wr = 1'b1; ctrl.mem_byte = 1'b1; ctrl.layout = LAY_RSR; end
            8'h19: begin ctrl.cls = CLS_STORE; ctrl.mem_wr = 1'b1; ctrl.layout = LAY_RSR; end
            8'h08: begin ctrl.cls = CLS_CONST; ctrl.reg_we = 1'b1; ctrl.layout = LAY_U16; ctrl.ckind = CK_ZEXT16; end
            8'h15: begin ctrl.cls = CLS_CONST; ctrl.reg_we = 1'b1; ctrl.layout = LAY_U16; ctrl.ckind = CK_SHIFT16; end
            8'h16: begin ctrl.cls = CLS_CONST; ctrl.reg_we = 1'b1; ctrl.layout = LAY_S16; ctrl.ckind = CK_IPREL; end
            default: begin
                ctrl.illegal = 1'b1;
                ctrl.layout  = LAY_NONE;
            end
        endcase
    end
endmodule

// File: rtl/insn_dec_imm.sv
module insn_dec_imm
    import dec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  layout_e             layout,
    input  logic [FIELDS_W-1:0] fields,
    output logic [XLEN-1:0]     imm
);
    localparam int SC_SHIFT = 3;

    logic [FLD_W-1:0]  fx;
    logic [FLD_W-1:0]  fy;
    logic [HALF_W-1:0] fxy;

    assign fx  = fields[FIELDS_W-1 -: FLD_W];
    assign fy  = fields[HALF_W-1 -: FLD_W];
    assign fxy = fields[HALF_W-1:0];

    always_comb begin
        case (layout)
            LAY_RRR:     imm = {{(XLEN-FLD_W){1'b0}}, fx};
            LAY_RRR_SC8: imm = {{(XLEN-FLD_W-SC_SHIFT){1'b0}}, fy, {SC_SHIFT{1'b0}}};
            LAY_RSR:     imm = {{(XLEN-FLD_W){fy[FLD_W-1]}}, fy};
            LAY_J24:     imm = {{(XLEN-FIELDS_W){fields[FIELDS_W-1]}}, fields};
            LAY_U16:     imm = {{(XLEN-HALF_W){1'b0}}, fxy};
            LAY_S16:     imm = {{(XLEN-HALF_W){fxy[HALF_W-1]}}, fxy};
            default:     imm = '0;
        endcase
    end
endmodule

// File: rtl/insn_dec_const.sv
module insn_dec_const
    import dec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  const_e            kind,
    input  logic [HALF_W-1:0] xy,
    input  logic [XLEN-1:0]   ip,
    input  logic [XLEN-1:0]   rz_val,
    output logic              valid,
    output logic [XLEN-1:0]   value
);
    logic [XLEN-1:0] xy_zext;
    logic [XLEN-1:0] xy_sext;

    assign xy_zext = {{(XLEN-HALF_W){1'b0}}, xy};
    assign xy_sext = {{(XLEN-HALF_W){xy[HALF_W-1]}}, xy};

    always_comb begin
        valid = (kind != CK_NONE);
        case (kind)
            CK_ZEXT16:  value = xy_zext;
            CK_SHIFT16: value = (rz_val << HALF_W) | xy_zext;
            CK_IPREL:   value = ip + xy_sext;
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import dec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   ip,
    input  logic [XLEN-1:0]   rz_val,
    output logic              illegal,
    output logic [2:0]        op_class,
    output logic [FLD_W-1:0]  rx,
    output logic [FLD_W-1:0]  ry,
    output logic [FLD_W-1:0]  rz,
    output logic [XLEN-1:0]   imm,
    output logic [2:0]        alu_op,
    output logic              x_is_imm,
    output logic [2:0]        br_cond,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_byte,
    output logic              reg_we,
    output logic              pair_we,
    output logic              link_we,
    output logic [1:0]        sys_op,
    output logic              wb_const_valid,
    output logic [XLEN-1:0]   wb_value
);
    typedef struct packed {
        logic              illegal;
        op_class_e         cls;
        logic [FLD_W-1:0]  rx;
        logic [FLD_W-1:0]  ry;
        logic [FLD_W-1:0]  rz;
        logic [XLEN-1:0]   imm;
        alu_e              alu;
        logic              x_imm;
        br_e               br;
        logic              mem_rd;
        logic              mem_wr;
        logic              mem_byte;
        logic              reg_we;
        logic              pair_we;
        logic              link_we;
        sys_e              sys;
        logic              wb_valid;
        logic [XLEN-1:0]   wb_value;
    } dec_t;

    ctrl_t           ctrl;
    logic [XLEN-1:0] imm_c;
    logic            cv_c;
    logic [XLEN-1:0] cval_c;
    dec_t            dec_d;
    dec_t            dec_q;

    insn_dec_ctrl i_ctrl (
        .opcode (insn[INSN_W-1 -: OP_W]),
        .ctrl   (ctrl)
    );

    insn_dec_imm #(.XLEN(XLEN)) i_imm (
        .layout (ctrl.layout),
        .fields (insn[FIELDS_W-1:0]),
        .imm    (imm_c)
    );

    insn_dec_const #(.XLEN(XLEN)) i_const (
        .kind   (ctrl.ckind),
        .xy     (insn[HALF_W-1:0]),
        .ip     (ip),
        .rz_val (rz_val),
        .valid  (cv_c),
        .value  (cval_c)
    );

    always_comb begin
        dec_d          = '0;
        dec_d.illegal  = ctrl.illegal;
        dec_d.cls      = ctrl.cls;
        dec_d.rx       = insn[FIELDS_W-1 -: FLD_W];
        dec_d.ry       = insn[HALF_W-1 -: FLD_W];
        dec_d.rz       = insn[FLD_W-1:0];
        dec_d.imm      = imm_c;
        dec_d.alu      = ctrl.alu;
        dec_d.x_imm    = ctrl.x_imm;
        dec_d.br       = ctrl.br;
        dec_d.mem_rd   = ctrl.mem_rd;
        dec_d.mem_wr   = ctrl.mem_wr;
        dec_d.mem_byte = ctrl.mem_byte;
        dec_d.reg_we   = ctrl.reg_we;
        dec_d.pair_we  = ctrl.pair_we;
        dec_d.link_we  = ctrl.link_we;
        dec_d.sys      = ctrl.sys;
        dec_d.wb_valid = cv_c;
        dec_d.wb_value = cval_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign illegal        = dec_q.illegal;
    assign op_class       = dec_q.cls;
    assign rx             = dec_q.rx;
    assign ry             = dec_q.ry;
    assign rz             = dec_q.rz;
    assign imm            = dec_q.imm;
    assign alu_op         = dec_q.alu;
    assign x_is_imm       = dec_q.x_imm;
    assign br_cond        = dec_q.br;
    assign mem_rd         = dec_q.mem_rd;
    assign mem_wr         = dec_q.mem_wr;
    assign mem_byte       = dec_q.mem_byte;
    assign reg_we         = dec_q.reg_we;
    assign pair_we        = dec_q.pair_we;
    assign link_we        = dec_q.link_we;
    assign sys_op         = dec_q.sys;
    assign wb_const_valid = dec_q.wb_valid;
    assign wb_value       = dec_q.wb_value;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk
    import dec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [INSN_W-1:0] insn,
    input logic [XLEN-1:0]   ip,
    input logic [XLEN-1:0]   rz_val,
    input logic              illegal,
    input logic [FLD_W-1:0]  rz,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              reg_we,
    input logic              pair_we,
    input logic              link_we,
    input logic              wb_const_valid,
    input logic [XLEN-1:0]   wb_value
);
    logic [OP_W-1:0] opc;
    assign opc = insn[INSN_W-1 -: OP_W];

    assert_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == opc) |=> (rz == $past(insn[FLD_W-1:0])));

    assert_mem_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_zext16_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 8'h08) |=> (wb_const_valid &&
            wb_value == {{(XLEN-HALF_W){1'b0}}, $past(insn[HALF_W-1:0])}));

    assert_shift16_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 8'h15) |=> (wb_const_valid &&
            wb_value == (($past(rz_val) << HALF_W) |
                         {{(XLEN-HALF_W){1'b0}}, $past(insn[HALF_W-1:0])})));

    assert_iprel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 8'h16) |=> (wb_const_valid &&
            wb_value == $past(ip) + {{(XLEN-HALF_W){$past(insn[HALF_W-1])}},
                                     $past(insn[HALF_W-1:0])}));

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 8'h00 || opc > 8'h1A) |=> (illegal && !reg_we && !pair_we &&
            !link_we && !mem_rd && !mem_wr && !wb_const_valid));
endmodule

bind insn_decoder insn_decoder_chk #(.XLEN(XLEN)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .insn           (insn),
    .ip             (ip),
    .rz_val         (rz_val),
    .illegal        (illegal),
    .rz             (rz),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .reg_we         (reg_we),
    .pair_we        (pair_we),
    .link_we        (link_we),
    .wb_const_valid (wb_const_valid),
    .wb_value       (wb_value)
);

// File: tb/test_insn_decoder.sv
module test_insn_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     insn = '0;
    logic [63:0]     ip = '0;
    logic [63:0]     rz_val = '0;
    logic            illegal, x_is_imm, mem_rd, mem_wr, mem_byte;
    logic            reg_we, pair_we, link_we, wb_const_valid;
    logic [2:0]      op_class, alu_op, br_cond;
    logic [1:0]      sys_op;
    logic [7:0]      rx, ry, rz;
    logic [63:0]     imm, wb_value;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_decoder #(.XLEN(XLEN)) i_insn_decoder (
        .clk(clk), .rst_n(rst_n), .insn(insn), .ip(ip), .rz_val(rz_val),
        .illegal(illegal), .op_class(op_class), .rx(rx), .ry(ry), .rz(rz),
        .imm(imm), .alu_op(alu_op), .x_is_imm(x_is_imm), .br_cond(br_cond),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
        .reg_we(reg_we), .pair_we(pair_we), .link_we(link_we),
        .sys_op(sys_op), .wb_const_valid(wb_const_valid), .wb_value(wb_value)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s insn=%h: got %h expected %h", req, what, insn, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Expected values from the requirement lists, checked one falling edge after driving.
    task automatic verify(input logic [7:0] op, input logic [23:0] f,
                          input logic [63:0] ipv, input logic [63:0] rzv);
        logic        legal;
        logic [2:0]  e_cls, e_alu, e_br;
        logic [1:0]  e_sys;
        logic [63:0] e_imm, e_wb;
        legal = (op >= 8'h01 && op <= 8'h1A);

        e_cls = 3'd0;
        if (op inside {8'h05, 8'h0A, 8'h0B, 8'h0E, 8'h0F, 8'h10, 8'h18, 8'h1A}) e_cls = 3'd1;
        if (op inside {8'h04, 8'h06, 8'h07, 8'h0C, 8'h0D}) e_cls = 3'd2;
        if (op == 8'h14) e_cls = 3'd3;
        if (op inside {8'h09, 8'h12, 8'h17}) e_cls = 3'd4;
        if (op inside {8'h11, 8'h19}) e_cls = 3'd5;
        if (op inside {8'h08, 8'h15, 8'h16}) e_cls = 3'd6;
        if (op inside {8'h01, 8'h02, 8'h03, 8'h13}) e_cls = 3'd7;

        e_alu = 3'd0;
        if (op inside {8'h0A, 8'h0E}) e_alu = 3'd1;
        if (op inside {8'h05, 8'h18}) e_alu = 3'd2;
        if (op inside {8'h0F, 8'h0B}) e_alu = 3'd3;
        if (op inside {8'h10, 8'h1A}) e_alu = 3'd4;

        e_br = 3'd0;
        if (op == 8'h04) e_br = 3'd1;
        if (op == 8'h06) e_br = 3'd2;
        if (op == 8'h07) e_br = 3'd3;
        if (op == 8'h0C) e_br = 3'd4;
        if (op == 8'h0D) e_br = 3'd5;

        e_sys = 2'd0;
        if (op == 8'h01) e_sys = 2'd1;
        if (op == 8'h02) e_sys = 2'd2;
        if (op inside {8'h03, 8'h13}) e_sys = 2'd3;

        if (!legal)                                       e_imm = 64'd0;
        else if (e_cls == 3'd2)                           e_imm = {{40{f[23]}}, f};
        else if (op inside {8'h08, 8'h15})                e_imm = {48'd0, f[15:0]};
        else if (op == 8'h16)                             e_imm = {{48{f[15]}}, f[15:0]};
        else if (op inside {8'h09, 8'h11, 8'h12, 8'h19}) e_imm = {{56{f[15]}}, f[15:8]};
        else if (op == 8'h17)                             e_imm = 64'(f[15:8]) * 64'd8;
        else                                              e_imm = {56'd0, f[23:16]};

        e_wb = 64'd0;
        if (op == 8'h08) e_wb = 64'(f[15:0]);
        if (op == 8'h15) e_wb = (rzv * 64'd65536) + 64'(f[15:0]);
        if (op == 8'h16) e_wb = ipv + {{48{f[15]}}, f[15:0]};

        chk("R10", "illegal", 64'(illegal), 64'(!legal));
        chk("R9",  "op_class", 64'(op_class), 64'(e_cls));
        chk("R9",  "sys_op", 64'(sys_op), 64'(e_sys));
        chk("R2",  "rx", 64'(rx), 64'(f[23:16]));
        chk("R2",  "ry", 64'(ry), 64'(f[15:8]));
        chk("R2",  "rz", 64'(rz), 64'(f[7:0]));
        chk("R3",  "imm", imm, e_imm);
        chk("R4",  "alu_op", 64'(alu_op), 64'(e_alu));
        chk("R4",  "x_is_imm", 64'(x_is_imm),
            64'(op inside {8'h05, 8'h0A, 8'h0F, 8'h10, 8'h13}));
        chk("R5",  "mem_rd", 64'(mem_rd), 64'(op inside {8'h09, 8'h12, 8'h17}));
        chk("R5",  "mem_wr", 64'(mem_wr), 64'(op inside {8'h11, 8'h19}));
        chk("R5",  "mem_byte", 64'(mem_byte), 64'(op inside {8'h09, 8'h11}));
        chk("R7",  "br_cond", 64'(br_cond), 64'(e_br));
        chk("R7",  "link_we", 64'(link_we), 64'(op == 8'h14));
        chk("R8",  "reg_we", 64'(reg_we), 64'(op inside {8'h02, 8'h05, 8'h08, 8'h09,
            8'h0A, 8'h0B, 8'h0E, 8'h0F, 8'h10, 8'h12, 8'h15, 8'h16, 8'h17, 8'h18, 8'h1A}));
        chk("R8",  "pair_we", 64'(pair_we), 64'(op inside {8'h10, 8'h1A}));
        chk("R6",  "wb_const_valid", 64'(wb_const_valid), 64'(op inside {8'h08, 8'h15, 8'h16}));
        chk("R6",  "wb_value", wb_value, e_wb);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset holds every output at zero even with a legal instruction applied
        insn   = 32'h1501_8002;
        ip     = 64'h40;
        rz_val = 64'hFFFF;
        repeat (3) @(negedge clk);
        chk("R1", "illegal@reset", 64'(illegal), 64'd0);
        chk("R1", "op_class@reset", 64'(op_class), 64'd0);
        chk("R1", "reg_we@reset", 64'(reg_we), 64'd0);
        chk("R1", "wb_value@reset", wb_value, 64'd0);
        chk("R1", "imm@reset", imm, 64'd0);
        rst_n = 1'b1;

        for (int o = 0; o < 256; o++) begin
            for (int p = 0; p < 5; p++) begin
                logic [7:0]  op;
                logic [23:0] f;
                logic [63:0] ipv, rzv;
                op = 8'(o);
                case (p)
                    0: f = 24'h000000;
                    1: f = 24'hFFFFFF;
                    2: f = 24'h807F01;
                    3: f = 24'h7F80FE;
                    default: f = {op, ~op, op + 8'd1};
                endcase
                ipv = (p == 1) ? 64'h0000_0000_0000_0004 : 64'h0000_0000_0040_0000 + 64'(o);
                rzv = 64'hFEDC_BA98_7654_3210 ^ {56'd0, op};
                insn   = {op, f};
                ip     = ipv;
                rz_val = rzv;
                // R1: one register stage, so the result is due after the next rising edge
                @(negedge clk);
                verify(op, f, ipv, rzv);
            end
        end
        finish_run();
    end
endmodule